// File: doc/BRIEF.md
# Ethernet Coprocessor Control-Block Command Controller

This block sits on the host side of a descriptor-driven Ethernet coprocessor and handles its control path only. The host writes to one 16-bit port. Two writes in a row form one 32-bit port access. The four lowest bits of that access choose an operation: reset, self-test, load a new system-configuration pointer, dump, or channel attention. The remaining bits, with the selector nibble zeroed, form the operation's argument.

The block holds the control-block command word as a register that the host writes. On a channel attention it reads this word, clears the event flags the host acknowledges, and applies the codes for the command unit and the receive unit. It then publishes a fresh status word, clears the command word and, where a code calls for it, raises a level interrupt. The first attention after any reset is an initialisation handshake: it decodes no commands. A command-unit start code does not walk any list here. It produces a one-cycle request on `cmd_list_start`, and the command unit then falls back to idle. Codes the block does not know set a sticky error flag.

Top module: `ecp_scb_ctrl`

## Requirements
- R1: A port access is two `hw_wr` writes, low half first and high half second. Bits 3:0 of the combined word are the operation code. The argument is the combined word with bits 3:0 forced to zero.
- R2: Reset (`rst`, or operation code 0) sets `scp_addr` to 0x00FFFFF4 and `scp_pending` to 1. It clears `status_word`, all event flags, and the receive state to idle (0).
- R3: Operation code 2 loads `scp_addr` with the argument and sets `scp_pending` only if the argument is nonzero. Codes 1, 3 and 5 to 15 change no output.
- R4: A channel attention (code 4) with `scp_pending` set performs initialisation. Event flags become CX and CNA, so `status_word` = 0xA008. The receive state goes idle, `scp_pending` clears and `irq` rises. The command word is not decoded, so there is no start request and no error.
- R5: Otherwise the attention first clears every event flag whose acknowledge bit is set in command word bits 15:12 (bit15 CX, bit14 FR, bit13 CNA, bit12 RNR). It then applies the unit codes, so a flag that a code sets in the same attention stays set.
- R6: Command-unit code in bits 10:8: 0, 5 and 6 do nothing. 1 pulses `cmd_list_start` for one cycle and raises `irq`. 4 sets CNA and raises `irq`. 2, 3 and 7 set `cmd_err`.
- R7: Receive-unit code in bits 6:4: 0 does nothing. 1 and 2 set the receive state to ready (4). 3 sets it to suspended (1). 4 sets it to idle (0). Codes 3 and 4 also set RNR and raise `irq`. Codes 5 to 7 set `cmd_err`.
- R8: After every attention `status_word` = {CX,FR,CNA,RNR} in bits 15:12, command-unit state in bits 10:8 (always idle, 0), receive state in bits 7:4, and 0x8 in bits 3:0.
- R9: Every channel attention clears the command word `cmdw` to 0, even if the host writes it in the same cycle.
- R10: `irq` is a level. It stays high until `irq_clr`, and an attention that sets it does not lower it otherwise.
- R11: `cmd_err` is sticky. Only `rst` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_wr | input | 1 | Host 16-bit port write strobe |
| hw_wdata | input | HW (16) | Host port write data |
| cmdw_wr | input | 1 | Host write of the command word |
| cmdw_wdata | input | 16 | Command word write data |
| irq_clr | input | 1 | Host clear of the interrupt level |
| cmdw | output | 16 | Current command word |
| status_word | output | 16 | Published status word |
| scp_addr | output | 2*HW (32) | System-configuration pointer |
| scp_pending | output | 1 | Next attention performs initialisation |
| irq | output | 1 | Interrupt request level |
| cmd_list_start | output | 1 | One-cycle request to run the command list |
| cmd_err | output | 1 | Sticky unknown-code flag |

## Verification
The assertions assume that the host never issues a second port access within two cycles of the first. A single-write pairing and the decode stage then never overlap. They also assume `rst` is held for at least one edge before any stimulus. The stimulus keeps to this because every port access is followed by idle cycles before the next action. Command-word writes and interrupt clears are issued in their own cycles, apart from attentions. Random command words are drawn from every unit code and every acknowledge pattern, so the known-code paths and the error paths are both reached.

// File: rtl/ecp_scb_pkg.sv
package ecp_scb_pkg;
  // port operation selectors (low nibble of a paired access)
  localparam logic [3:0] OP_RESET    = 4'd0;
  localparam logic [3:0] OP_SELFTEST = 4'd1;
  localparam logic [3:0] OP_ALTSCP   = 4'd2;
  localparam logic [3:0] OP_DUMP     = 4'd3;
  localparam logic [3:0] OP_ATTN     = 4'd4;

  // event flag positions inside the 4-bit event vector (same order as bits 15:12)
  localparam int EV_CX  = 3;
  localparam int EV_FR  = 2;
  localparam int EV_CNA = 1;
  localparam int EV_RNR = 0;

  localparam logic [3:0] RU_IDLE  = 4'd0;
  localparam logic [3:0] RU_SUSP  = 4'd1;
  localparam logic [3:0] RU_READY = 4'd4;
  localparam logic [2:0] CU_IDLE  = 3'd0;

  function automatic logic [15:0] pack_status(input logic [3:0] ev,
                                              input logic [2:0] cu,
                                              input logic [3:0] ru);
    return {ev, 1'b0, cu, ru, 4'b1000};
  endfunction
endpackage

// File: rtl/ecp_port_pair.sv
module ecp_port_pair #(
  parameter int HW   = 16,
  parameter int SELW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_vld,
  input  logic [HW-1:0]   wr_data,
  output logic            op_vld,
  output logic [SELW-1:0] op_code,
  output logic [2*HW-1:0] op_arg
);
  logic          phase_q;
  logic [HW-1:0] low_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= 1'b0;
      low_q   <= '0;
      op_vld  <= 1'b0;
      op_code <= '0;
      op_arg  <= '0;
    end else begin
      op_vld <= 1'b0;
      if (wr_vld) begin
        if (!phase_q) begin
          low_q   <= wr_data;
          phase_q <= 1'b1;
        end else begin
          phase_q <= 1'b0;
          op_vld  <= 1'b1;
          op_code <= low_q[SELW-1:0];
          op_arg  <= {wr_data, low_q[HW-1:SELW], {SELW{1'b0}}};
        end
      end
    end
  end
endmodule

// File: rtl/ecp_ca_decode.sv
module ecp_ca_decode
  import ecp_scb_pkg::*;
(
  input  logic [15:0] cmd,
  input  logic [3:0]  ev_in,
  input  logic [3:0]  ru_in,
  output logic [3:0]  ev_out,
  output logic [3:0]  ru_out,
  output logic        cu_start,
  output logic        irq_req,
  output logic        unknown
);
  always_comb begin
    ev_out   = ev_in & ~cmd[15:12];
    ru_out   = ru_in;
    cu_start = 1'b0;
    irq_req  = 1'b0;
    unknown  = 1'b0;
    case (cmd[10:8])
      3'd0, 3'd5, 3'd6: ;
      3'd1: begin
        cu_start = 1'b1;
        irq_req  = 1'b1;
      end
      3'd4: begin
        ev_out[EV_CNA] = 1'b1;
        irq_req        = 1'b1;
      end
      default: unknown = 1'b1;
    endcase
    case (cmd[6:4])
      3'd0: ;
      3'd1, 3'd2: ru_out = RU_READY;
      3'd3: begin
        ru_out         = RU_SUSP;
        ev_out[EV_RNR] = 1'b1;
        irq_req        = 1'b1;
      end
      3'd4: begin
        ru_out         = RU_IDLE;
        ev_out[EV_RNR] = 1'b1;
        irq_req        = 1'b1;
      end
      default: unknown = 1'b1;
    endcase
  end
endmodule

// File: rtl/ecp_scb_ctrl.sv
module ecp_scb_ctrl
  import ecp_scb_pkg::*;
#(
  parameter int              HW      = 16,
  parameter int              SELW    = 4,
  parameter logic [2*HW-1:0] SCP_RST = 32'h00FF_FFF4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hw_wr,
  input  logic [HW-1:0]   hw_wdata,
  input  logic            cmdw_wr,
  input  logic [15:0]     cmdw_wdata,
  input  logic            irq_clr,
  output logic [15:0]     cmdw,
  output logic [15:0]     status_word,
  output logic [2*HW-1:0] scp_addr,
  output logic            scp_pending,
  output logic            irq,
  output logic            cmd_list_start,
  output logic            cmd_err
);
  localparam int WW = 2 * HW;
  localparam logic [3:0] EV_INIT = 4'b1010;

  logic            op_vld;
  logic [SELW-1:0] op_code;
  logic [WW-1:0]   op_arg;
  logic [3:0]      ev_q, ru_q, dec_ev, dec_ru;
  logic            dec_start, dec_irq, dec_unk;
  logic            ca_fire;

  ecp_port_pair #(.HW(HW), .SELW(SELW)) u_pair (
    .clk(clk), .rst(rst), .wr_vld(hw_wr), .wr_data(hw_wdata),
    .op_vld(op_vld), .op_code(op_code), .op_arg(op_arg)
  );

  ecp_ca_decode u_dec (
    .cmd(cmdw), .ev_in(ev_q), .ru_in(ru_q),
    .ev_out(dec_ev), .ru_out(dec_ru),
    .cu_start(dec_start), .irq_req(dec_irq), .unknown(dec_unk)
  );

  assign ca_fire = op_vld && (op_code == SELW'(OP_ATTN));

  always_ff @(posedge clk) begin
    if (rst) begin
      scp_addr       <= SCP_RST;
      scp_pending    <= 1'b1;
      ev_q           <= '0;
      ru_q           <= RU_IDLE;
      status_word    <= '0;
      cmdw           <= '0;
      irq            <= 1'b0;
      cmd_list_start <= 1'b0;
      cmd_err        <= 1'b0;
    end else begin
      cmd_list_start <= 1'b0;
      if (cmdw_wr) cmdw <= cmdw_wdata;
      if (irq_clr) irq <= 1'b0;
      if (op_vld) begin
        if (op_code == SELW'(OP_RESET)) begin
          scp_addr    <= SCP_RST;
          scp_pending <= 1'b1;
          ev_q        <= '0;
          ru_q        <= RU_IDLE;
          status_word <= '0;
        end else if (op_code == SELW'(OP_ALTSCP)) begin
          scp_addr    <= op_arg;
          scp_pending <= |op_arg;
        end
      end
      if (ca_fire) begin
        cmdw <= '0;
        if (scp_pending) begin
          ev_q        <= EV_INIT;
          ru_q        <= RU_IDLE;
          scp_pending <= 1'b0;
          irq         <= 1'b1;
          status_word <= pack_status(EV_INIT, CU_IDLE, RU_IDLE);
        end else begin
          ev_q           <= dec_ev;
          ru_q           <= dec_ru;
          status_word    <= pack_status(dec_ev, CU_IDLE, dec_ru);
          cmd_list_start <= dec_start;
          if (dec_irq) irq <= 1'b1;
          if (dec_unk) cmd_err <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ecp_scb_chk.sv
module ecp_scb_chk (
  input logic        clk,
  input logic        rst,
  input logic        irq,
  input logic        irq_clr,
  input logic        cmd_list_start,
  input logic        cmd_err,
  input logic [15:0] status_word,
  input logic [15:0] cmdw
);
  AST_CONST_NIBBLE: assert property (@(posedge clk) disable iff (rst)
    (status_word != 16'h0) |-> (status_word[3:0] == 4'h8)); // R8
  AST_CU_FIELD_IDLE: assert property (@(posedge clk) disable iff (rst)
    status_word[11:8] == 4'h0); // R8
  AST_RU_FIELD_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (status_word[7:4] == 4'd0) || (status_word[7:4] == 4'd1) || (status_word[7:4] == 4'd4)); // R7
  AST_START_WITH_IRQ: assert property (@(posedge clk) disable iff (rst)
    cmd_list_start |-> irq); // R6
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    cmd_list_start |=> !cmd_list_start); // R6
  AST_START_CMDW_ZERO: assert property (@(posedge clk) disable iff (rst)
    cmd_list_start |-> (cmdw == 16'h0)); // R9
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clr) |=> irq); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    cmd_err |=> cmd_err); // R11
endmodule

bind ecp_scb_ctrl ecp_scb_chk u_chk (
  .clk(clk), .rst(rst), .irq(irq), .irq_clr(irq_clr),
  .cmd_list_start(cmd_list_start), .cmd_err(cmd_err),
  .status_word(status_word), .cmdw(cmdw)
);

// File: tb/sim_ecp_scb_ctrl.sv
module sim_ecp_scb_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hw_wr = 1'b0;
  logic [15:0] hw_wdata = '0;
  logic        cmdw_wr = 1'b0;
  logic [15:0] cmdw_wdata = '0;
  logic        irq_clr = 1'b0;
  logic [15:0] cmdw, status_word;
  logic [31:0] scp_addr;
  logic        scp_pending, irq, cmd_list_start, cmd_err;

  int n_run = 0, n_fail = 0, obs_starts = 0, exp_starts = 0;
  bit done = 1'b0;

  logic [31:0] m_scp;
  logic        m_pend, m_irq, m_err;
  logic [3:0]  m_ev, m_ru;
  logic [15:0] m_stat, m_cmdw;

  always #2 clk = ~clk;

  ecp_scb_ctrl u0 (
    .clk(clk), .rst(rst), .hw_wr(hw_wr), .hw_wdata(hw_wdata),
    .cmdw_wr(cmdw_wr), .cmdw_wdata(cmdw_wdata), .irq_clr(irq_clr),
    .cmdw(cmdw), .status_word(status_word), .scp_addr(scp_addr),
    .scp_pending(scp_pending), .irq(irq), .cmd_list_start(cmd_list_start),
    .cmd_err(cmd_err)
  );

  always @(negedge clk) if (!rst && cmd_list_start === 1'b1) obs_starts++;

  function automatic logic [15:0] exp_status(input logic [3:0] ev, input logic [3:0] ru);
    return {ev, 4'h0, ru, 4'h8};
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "cmdw", {16'h0, cmdw}, {16'h0, m_cmdw});
    chk(tag, "status_word", {16'h0, status_word}, {16'h0, m_stat});
    chk(tag, "scp_addr", scp_addr, m_scp);
    chk(tag, "scp_pending", {31'h0, scp_pending}, {31'h0, m_pend});
    chk(tag, "irq", {31'h0, irq}, {31'h0, m_irq});
    chk(tag, "cmd_err", {31'h0, cmd_err}, {31'h0, m_err});
    chk(tag, "start_count", obs_starts, exp_starts);
  endtask

  task automatic model_reset();
    m_scp = 32'h00FF_FFF4; m_pend = 1'b1; m_ev = 4'h0; m_ru = 4'd0; m_stat = 16'h0;
  endtask

  // channel attention model per R4..R9
  task automatic model_ca();
    logic [2:0] cu, ru;
    if (m_pend) begin
      m_ev = 4'b1010; m_ru = 4'd0; m_pend = 1'b0; m_irq = 1'b1;
    end else begin
      m_ev = m_ev & ~m_cmdw[15:12];
      cu = m_cmdw[10:8];
      ru = m_cmdw[6:4];
      if (cu == 3'd1) begin exp_starts++; m_irq = 1'b1; end
      else if (cu == 3'd4) begin m_ev[1] = 1'b1; m_irq = 1'b1; end
      else if (cu == 3'd2 || cu == 3'd3 || cu == 3'd7) m_err = 1'b1;
      if (ru == 3'd1 || ru == 3'd2) m_ru = 4'd4;
      else if (ru == 3'd3) begin m_ru = 4'd1; m_ev[0] = 1'b1; m_irq = 1'b1; end
      else if (ru == 3'd4) begin m_ru = 4'd0; m_ev[0] = 1'b1; m_irq = 1'b1; end
      else if (ru != 3'd0) m_err = 1'b1;
    end
    m_stat = exp_status(m_ev, m_ru);
    m_cmdw = 16'h0;
  endtask

  task automatic port_wr(input logic [31:0] v);
    case (v[3:0])
      4'd0: model_reset();
      4'd2: begin m_scp = {v[31:4], 4'h0}; m_pend = (m_scp != 32'h0); end
      4'd4: model_ca();
      default: ;
    endcase
    @(negedge clk); hw_wr = 1'b1; hw_wdata = v[15:0];
    @(negedge clk); hw_wdata = v[31:16];
    @(negedge clk); hw_wr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic set_cmdw(input logic [15:0] v);
    @(negedge clk); cmdw_wr = 1'b1; cmdw_wdata = v;
    @(negedge clk); cmdw_wr = 1'b0;
    m_cmdw = v;
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    m_irq = 1'b0;
  endtask

  task automatic ca_with(input logic [15:0] v);
    set_cmdw(v);
    port_wr(32'h0000_0004);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset(); m_irq = 1'b0; m_err = 1'b0; m_cmdw = 16'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_all("R2");                       // reset state

    ca_with(16'h0110);                     // R4: init handshake ignores codes
    check_all("R4");
    chk("R9", "cmdw_cleared", {16'h0, cmdw}, 32'h0);

    clear_irq();
    check_all("R10");

    ca_with(16'h8000);                     // R5: ack CX only, no irq request
    check_all("R5");

    ca_with(16'h2410);                     // R5/R6/R7: ack CNA then re-set by abort
    check_all("R6");
    chk("R8", "status_word", {16'h0, status_word}, 32'h2048);

    ca_with(16'h0100);                     // R6: start pulse
    check_all("R6");

    ca_with(16'h0030);                     // R7: receive suspend sets RNR
    check_all("R7");

    ca_with(16'h0200);                     // R11: unknown command-unit code
    check_all("R11");
    ca_with(16'h0000);
    check_all("R11");

    ca_with(16'h0070);                     // R7: unknown receive-unit code
    check_all("R7");

    port_wr(32'h1234_5672);                // R1/R3: argument has nibble cleared
    check_all("R1");
    port_wr(32'h0000_0002);                // R3: zero pointer leaves nothing pending
    check_all("R3");
    ca_with(16'h0610);                     // decoded (not init), code 6 is a no-op
    check_all("R3");
    port_wr(32'hABCD_EF01);                // R3: ignored operations
    port_wr(32'h5555_0003);
    port_wr(32'h0F0F_0009);
    check_all("R3");

    port_wr(32'h7777_7770);                // R2: software reset
    check_all("R2");

    for (int i = 0; i < 300; i++) begin
      int r;
      logic [15:0] w;
      r = $urandom % 8;
      w = {4'($urandom), 1'b0, 3'($urandom), 1'b0, 3'($urandom), 4'($urandom)};
      case (r)
        0, 1, 2: ca_with(w);
        3: clear_irq();
        4: port_wr({$urandom} | 32'h2 & 32'hFFFF_FFF2);
        5: port_wr({$urandom} & 32'hFFFF_FFF0 | 32'h3);
        6: if ($urandom % 4 == 0) port_wr(32'h0); else set_cmdw(w);
        default: port_wr(32'h4);
      endcase
      check_all("R8");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule